// File: doc/BRIEF.md
# Watchdog Timer with Dual-Clear Mode

This block is the watchdog counter of a small microcontroller core. Each cycle of the core clock it takes one count strobe from a source chosen by configuration. The sources are a slow RC oscillator, a free-running instruction-rate strobe at one quarter of the core clock, or a 32768 Hz real-time oscillator. The oscillator circuits sit outside the block and deliver their edges as one-cycle strobes in the core clock domain. The strobes advance an 8-stage fixed divider that feeds a 7-bit prescaler. A two-bit tap code picks the overflow point, at 2^12, 2^13, 2^14 or 2^15 strobes.

Software keeps the watchdog quiet with clear commands. Two clear disciplines are available. In single-clear mode one plain clear command is enough. In dual-clear mode two separate commands must both be seen before the count restarts, in either order and in any cycles. Executing HALT also restarts the count. Clear commands restart only the prescaler, so the divider phase stays free.

On overflow the block issues a one-cycle reset strobe. A running core gets a full chip-reset strobe and the time-out flag is set. A halted core gets a warm-reset strobe, which the core uses to zero only its program counter and stack pointer. The external reset input is taken to be already released synchronously to `clk`.

Top module: `wdog_core`

## Requirements
- R1: `cfg_src` chooses the count strobe: code 0 and code 3 take `rc_tick`, code 1 takes the internal instruction-rate strobe (one strobe every fourth clock, the first on the fourth edge after reset), and code 2 takes `rtc_tick`. Strobes from sources that are not selected have no effect.
- R2: With tap code k on `cfg_tap`, the overflow falls on the 2^(12+k)-th selected strobe counted from reset or from enabling. After a clear command, the next overflow comes between 2^(12+k)-255 and 2^(12+k) strobes later, depending on the divider phase.
- R3: An overflow while `halted` is low drives `chip_rst_o` high for exactly the one cycle after the overflow edge, and sets `to_flag_o` at that same edge.
- R4: An overflow while `halted` is high drives `warm_rst_o` high for one cycle instead, and leaves `to_flag_o` unchanged. `chip_rst_o` and `warm_rst_o` are never high together.
- R5: While `cfg_en` is low, the counters are held at zero, clear commands do nothing and neither reset strobe is produced. After `cfg_en` rises, the count starts from zero.
- R6: With `cfg_dual` low, a `clr_one` pulse restarts the prescaler, and `clr1` and `clr2` are ignored.
- R7: With `cfg_dual` high, the prescaler restarts only once both `clr1` and `clr2` have been seen since the last restart. They may come in the same cycle or in different cycles. `clr_one` is ignored, and both pending marks are dropped when the restart happens.
- R8: A `halt_exec` pulse restarts the prescaler in either clear mode.
- R9: While `halted` is high, the instruction-rate strobe is frozen, so with `cfg_src` equal to 1 the count does not advance.
- R10: `to_flag_o` stays set until `rst_n` goes low or `to_clr` is pulsed. A new chip-reset overflow in the same cycle as `to_clr` wins, and the flag stays set.
- R11: A clear command sampled at the same edge as an overflow cancels it: no strobe is issued, and the count restarts.
- R12: While `rst_n` is low, `chip_rst_o`, `warm_rst_o` and `to_flag_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | External active-low reset, asynchronous assert |
| cfg_en | input | 1 | Watchdog enable option |
| cfg_src | input | 2 | Count source select (0/3 RC, 1 instruction rate, 2 RTC) |
| cfg_tap | input | 2 | Time-out tap code k, overflow at 2^(12+k) strobes |
| cfg_dual | input | 1 | 1 selects dual-clear mode |
| rc_tick | input | 1 | One-cycle strobe per RC oscillator period |
| rtc_tick | input | 1 | One-cycle strobe per RTC oscillator period |
| clr_one | input | 1 | Single clear command strobe |
| clr1 | input | 1 | First dual clear command strobe |
| clr2 | input | 1 | Second dual clear command strobe |
| halt_exec | input | 1 | Strobe when a HALT instruction executes |
| halted | input | 1 | Core is in the halt state |
| to_clr | input | 1 | Software clear of the time-out flag |
| chip_rst_o | output | 1 | Full chip-reset strobe |
| warm_rst_o | output | 1 | Warm-reset strobe (PC and SP only) |
| to_flag_o | output | 1 | Time-out status flag |

## Verification
Each strobe or clear sampled at a clock edge takes effect in the counters at that same edge. A reset strobe and the time-out flag rise on the edge where the overflowing strobe is taken, so they can be seen in the cycle that follows. The bench drives its inputs a few nanoseconds after each rising edge. Its behavioural model advances on the rising edge, and outputs are compared at the falling edge, so each comparison sees the edge that has just passed. The directed timing checks count edges from reset release, from enabling or from the clear edge, and compare that count with the strobe totals worked out from R2. They cover the overflow after reset, after a clear late in a period, and after a clear that lands exactly on the overflow edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Count source codes on cfg_src
  typedef enum logic [1:0] {
    SRC_RC     = 2'd0,
    SRC_INSTR  = 2'd1,
    SRC_RTC    = 2'd2,
    SRC_RC_ALT = 2'd3
  } wdog_src_e;

  // Default geometry of the count chain
  localparam int unsigned WD_DIV_W    = 8;  // fixed divider stages
  localparam int unsigned WD_PRE_W    = 7;  // prescaler stages
  localparam int unsigned WD_TAP_W    = 2;  // tap code width
  localparam int unsigned WD_TAP_BASE = 4;  // prescaler stages used by tap 0
  localparam int unsigned WD_PHASE_W  = 2;  // instruction-rate divider

  // Outcome of an overflow
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CHIP = 2'd1,
    ACT_WARM = 2'd2
  } wdog_act_e;

endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
  import wdog_pkg::*;
#(
  parameter int unsigned PHASE_W = WD_PHASE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_i,
  input  logic       rc_tick_i,
  input  logic       rtc_tick_i,
  input  logic       halted_i,
  output logic       tick_o
);

  localparam logic [PHASE_W-1:0] PHASE_LAST = '1;

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  logic               instr_tick;
  wdog_src_e          src_sel;

  // Instruction-rate phase, frozen while the core is halted
  always_comb begin
    phase_d = phase_q;
    if (!halted_i) begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign instr_tick = !halted_i && (phase_q == PHASE_LAST);
  assign src_sel    = wdog_src_e'(src_i);

  always_comb begin
    unique case (src_sel)
      SRC_INSTR: tick_o = instr_tick;
      SRC_RTC:   tick_o = rtc_tick_i;
      default:   tick_o = rc_tick_i;
    endcase
  end

endmodule

// File: rtl/wdog_clear_ctl.sv
module wdog_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dual_i,
  input  logic clr_one_i,
  input  logic clr1_i,
  input  logic clr2_i,
  input  logic halt_exec_i,
  input  logic ovf_i,
  output logic fire_o
);

  logic pend1_q, pend1_d;
  logic pend2_q, pend2_d;
  logic have1, have2;
  logic single_hit, dual_hit;

  assign have1      = pend1_q || clr1_i;
  assign have2      = pend2_q || clr2_i;
  assign single_hit = !dual_i && clr_one_i;
  assign dual_hit   = dual_i && have1 && have2;
  assign fire_o     = en_i && (halt_exec_i || single_hit || dual_hit);

  // Pending marks only live in dual mode while enabled
  always_comb begin
    pend1_d = pend1_q;
    pend2_d = pend2_q;
    if (!en_i || !dual_i || fire_o || ovf_i) begin
      pend1_d = 1'b0;
      pend2_d = 1'b0;
    end else begin
      pend1_d = have1;
      pend2_d = have2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend1_q <= 1'b0;
      pend2_q <= 1'b0;
    end else begin
      pend1_q <= pend1_d;
      pend2_q <= pend2_d;
    end
  end

endmodule

// File: rtl/wdog_chain.sv
module wdog_chain
  import wdog_pkg::*;
#(
  parameter int unsigned DIV_W    = WD_DIV_W,
  parameter int unsigned PRE_W    = WD_PRE_W,
  parameter int unsigned TAP_W    = WD_TAP_W,
  parameter int unsigned TAP_BASE = WD_TAP_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             ovf_o
);

  localparam int unsigned N_TAPS = 1 << TAP_W;
  localparam logic [DIV_W-1:0] DIV_LAST = '1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] lim_tab [N_TAPS];
  logic [PRE_W-1:0] pre_max;
  logic             carry;

  // Last prescaler value before overflow, one entry per tap
  for (genvar t = 0; t < N_TAPS; t++) begin : g_lim
    localparam int unsigned LIM_V = (1 << (TAP_BASE + t)) - 1;
    assign lim_tab[t] = PRE_W'(LIM_V);
  end

  assign pre_max = lim_tab[tap_i];
  assign carry   = en_i && tick_i && (div_q == DIV_LAST);
  assign ovf_o   = carry && (pre_q >= pre_max) && !clr_i;

  always_comb begin
    div_d = div_q;
    pre_d = pre_q;
    if (!en_i) begin
      div_d = '0;
      pre_d = '0;
    end else begin
      if (tick_i) begin
        div_d = div_q + 1'b1;
      end
      if (clr_i || ovf_o) begin
        pre_d = '0;
      end else if (carry) begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= div_d;
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned DIV_W    = WD_DIV_W,
  parameter int unsigned PRE_W    = WD_PRE_W,
  parameter int unsigned TAP_W    = WD_TAP_W,
  parameter int unsigned TAP_BASE = WD_TAP_BASE,
  parameter int unsigned PHASE_W  = WD_PHASE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_src,
  input  logic [TAP_W-1:0] cfg_tap,
  input  logic             cfg_dual,
  input  logic             rc_tick,
  input  logic             rtc_tick,
  input  logic             clr_one,
  input  logic             clr1,
  input  logic             clr2,
  input  logic             halt_exec,
  input  logic             halted,
  input  logic             to_clr,
  output logic             chip_rst_o,
  output logic             warm_rst_o,
  output logic             to_flag_o
);

  logic      tick;
  logic      clr_fire;
  logic      ovf;
  wdog_act_e act;
  logic      chip_q, chip_d;
  logic      warm_q, warm_d;
  logic      to_q, to_d;

  wdog_tick_sel #(
    .PHASE_W (PHASE_W)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (cfg_src),
    .rc_tick_i  (rc_tick),
    .rtc_tick_i (rtc_tick),
    .halted_i   (halted),
    .tick_o     (tick)
  );

  wdog_clear_ctl u_clr (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (cfg_en),
    .dual_i      (cfg_dual),
    .clr_one_i   (clr_one),
    .clr1_i      (clr1),
    .clr2_i      (clr2),
    .halt_exec_i (halt_exec),
    .ovf_i       (ovf),
    .fire_o      (clr_fire)
  );

  wdog_chain #(
    .DIV_W    (DIV_W),
    .PRE_W    (PRE_W),
    .TAP_W    (TAP_W),
    .TAP_BASE (TAP_BASE)
  ) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (cfg_en),
    .tick_i (tick),
    .clr_i  (clr_fire),
    .tap_i  (cfg_tap),
    .ovf_o  (ovf)
  );

  // Overflow outcome depends on the halt state
  always_comb begin
    act = ACT_NONE;
    if (ovf) begin
      act = halted ? ACT_WARM : ACT_CHIP;
    end
  end

  always_comb begin
    chip_d = (act == ACT_CHIP);
    warm_d = (act == ACT_WARM);
    to_d   = to_q;
    if (act == ACT_CHIP) begin
      to_d = 1'b1;
    end else if (to_clr) begin
      to_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q <= 1'b0;
      warm_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      chip_q <= chip_d;
      warm_q <= warm_d;
      to_q   <= to_d;
    end
  end

  assign chip_rst_o = chip_q;
  assign warm_rst_o = warm_q;
  assign to_flag_o  = to_q;

endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic halted,
  input logic to_clr,
  input logic clr_fire,
  input logic chip,
  input logic warm,
  input logic to_flag
);

  AST_CHIP_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
    chip |-> to_flag); // R3

  AST_CHIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chip |=> !chip); // R3

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip && warm)); // R4

  AST_WARM_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> $past(halted)); // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_en) |-> (!chip && !warm)); // R5

  AST_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && !to_clr) |=> to_flag); // R10

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_fire) |-> (!chip && !warm)); // R11

endmodule

bind wdog_core wdog_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .halted   (halted),
  .to_clr   (to_clr),
  .clr_fire (clr_fire),
  .chip     (chip_rst_o),
  .warm     (warm_rst_o),
  .to_flag  (to_flag_o)
);

// File: tb/sim_wdog_core.sv
module sim_wdog_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b1;
  logic [1:0] cfg_src = 2'd0;
  logic [1:0] cfg_tap = 2'd0;
  logic       cfg_dual = 1'b0;
  logic       rc_tick = 1'b0;
  logic       rtc_tick = 1'b0;
  logic       clr_one = 1'b0;
  logic       clr1 = 1'b0;
  logic       clr2 = 1'b0;
  logic       halt_exec = 1'b0;
  logic       halted = 1'b0;
  logic       to_clr = 1'b0;
  logic       chip_rst_o, warm_rst_o, to_flag_o;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R12";

  always #10 clk = ~clk;

  wdog_core u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src(cfg_src),
    .cfg_tap(cfg_tap), .cfg_dual(cfg_dual), .rc_tick(rc_tick),
    .rtc_tick(rtc_tick), .clr_one(clr_one), .clr1(clr1), .clr2(clr2),
    .halt_exec(halt_exec), .halted(halted), .to_clr(to_clr),
    .chip_rst_o(chip_rst_o), .warm_rst_o(warm_rst_o), .to_flag_o(to_flag_o)
  );

  // Behavioural reference: integer counters of strobes
  int m_phase, m_div, m_pre;
  bit m_p1, m_p2, e_chip, e_warm, e_to;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_div = 0; m_pre = 0; m_p1 = 0; m_p2 = 0;
      e_chip = 0; e_warm = 0; e_to = 0;
    end else begin
      bit itick, tk, fire, carry, ovf;
      int lim;
      itick = !halted && (m_phase == 3);
      if (!halted) m_phase = (m_phase + 1) % 4;
      tk = (cfg_src == 2'd1) ? itick : (cfg_src == 2'd2) ? rtc_tick : rc_tick;
      ovf = 0;
      if (!cfg_en) begin
        m_div = 0; m_pre = 0; m_p1 = 0; m_p2 = 0;
      end else begin
        fire = halt_exec || (!cfg_dual && clr_one) ||
               (cfg_dual && (m_p1 || clr1) && (m_p2 || clr2));
        carry = tk && (m_div == 255);
        lim = (1 << (4 + cfg_tap)) - 1;
        ovf = carry && (m_pre >= lim) && !fire;
        if (tk) m_div = (m_div + 1) % 256;
        if (fire || ovf) m_pre = 0;
        else if (carry) m_pre = m_pre + 1;
        if (fire || ovf || !cfg_dual) begin
          m_p1 = 0; m_p2 = 0;
        end else begin
          m_p1 = m_p1 || clr1; m_p2 = m_p2 || clr2;
        end
      end
      e_chip = ovf && !halted;
      e_warm = ovf && halted;
      if (e_chip) e_to = 1;
      else if (to_clr) e_to = 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    n_chk++;
    if (chip_rst_o !== e_chip || warm_rst_o !== e_warm || to_flag_o !== e_to) begin
      n_bad++;
      $display("FAIL %s model compare: act chip=%b warm=%b to=%b exp chip=%b warm=%b to=%b",
               cur_req, chip_rst_o, warm_rst_o, to_flag_o, e_chip, e_warm, e_to);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #4;
  endtask

  task automatic do_reset();
    step();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  // kind: 1 clr_one, 2 clr1, 3 clr2, 4 halt_exec; result kind: 1 chip, 2 warm
  task automatic run_sched(input int maxc, input int c1, input int k1,
                           input int c2, input int k2,
                           output int at, output int kind);
    at = 0; kind = 0;
    clr_one = 0; clr1 = 0; clr2 = 0; halt_exec = 0;
    if (c1 == 1) begin
      clr_one = (k1 == 1); clr1 = (k1 == 2); clr2 = (k1 == 3); halt_exec = (k1 == 4);
    end
    for (int i = 1; i <= maxc; i++) begin
      step();
      if (at == 0 && (chip_rst_o || warm_rst_o)) begin
        at = i; kind = chip_rst_o ? 1 : 2;
      end
      clr_one = 0; clr1 = 0; clr2 = 0; halt_exec = 0;
      if (at != 0) break;
      if (i + 1 == c1) begin
        clr_one = (k1 == 1); clr1 = (k1 == 2); clr2 = (k1 == 3); halt_exec = (k1 == 4);
      end
      if (i + 1 == c2) begin
        clr_one = clr_one | (k2 == 1); clr1 = clr1 | (k2 == 2);
        clr2 = clr2 | (k2 == 3); halt_exec = halt_exec | (k2 == 4);
      end
    end
  endtask

  initial begin
    int at, kind;
    fork
      begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: act running exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    // R12 reset state
    step(); step();
    chk("R12 chip", chip_rst_o, 0);
    chk("R12 warm", warm_rst_o, 0);
    chk("R12 to", to_flag_o, 0);

    // R2 R3 tap 0 from reset, RC source
    cur_req = "R3";
    rc_tick = 1;
    rst_n = 1;
    run_sched(5000, 0, 0, 0, 0, at, kind);
    chk("R2 overflow edge tap0", at, 4096);
    chk("R3 chip kind", kind, 1);
    chk("R3 to set", to_flag_o, 1);
    step();
    chk("R3 one-cycle strobe", chip_rst_o, 0);

    // R10 flag held, then cleared by to_clr
    cur_req = "R10";
    repeat (50) step();
    chk("R10 to held", to_flag_o, 1);
    to_clr = 1; step(); to_clr = 0;
    chk("R10 to cleared", to_flag_o, 0);

    // R11 clear on the overflow edge
    cur_req = "R11";
    do_reset();
    run_sched(4096, 4096, 1, 0, 0, at, kind);
    chk("R11 overflow cancelled", at, 0);
    run_sched(5000, 0, 0, 0, 0, at, kind);
    chk("R11 next overflow", at, 4096);

    // R6 single mode
    cur_req = "R6";
    do_reset();
    run_sched(8000, 3000, 1, 0, 0, at, kind);
    chk("R6 clr_one restarts", at, 6912);
    do_reset();
    run_sched(8000, 1000, 2, 2000, 3, at, kind);
    chk("R6 clr1 clr2 ignored", at, 4096);

    // R7 dual mode
    cur_req = "R7";
    cfg_dual = 1;
    do_reset();
    run_sched(8000, 3000, 2, 0, 0, at, kind);
    chk("R7 clr1 alone", at, 4096);
    do_reset();
    run_sched(8000, 3000, 2, 3500, 3, at, kind);
    chk("R7 clr1 then clr2", at, 7424);
    do_reset();
    run_sched(8000, 3000, 3, 3000, 2, at, kind);
    chk("R7 both same cycle", at, 6912);
    do_reset();
    run_sched(8000, 3000, 1, 0, 0, at, kind);
    chk("R7 clr_one ignored", at, 4096);

    // R8 halt_exec clears in dual mode
    cur_req = "R8";
    do_reset();
    run_sched(8000, 3000, 4, 0, 0, at, kind);
    chk("R8 halt_exec restarts", at, 6912);
    cfg_dual = 0;

    // R4 overflow while halted
    cur_req = "R4";
    halted = 1;
    do_reset();
    run_sched(5000, 0, 0, 0, 0, at, kind);
    chk("R4 warm edge", at, 4096);
    chk("R4 warm kind", kind, 2);
    chk("R4 to unchanged", to_flag_o, 0);

    // R9 instruction source frozen while halted
    cur_req = "R9";
    cfg_src = 2'd1;
    do_reset();
    run_sched(18000, 0, 0, 0, 0, at, kind);
    chk("R9 frozen while halted", at, 0);
    halted = 0;
    run_sched(17000, 0, 0, 0, 0, at, kind);
    chk("R9 instruction rate overflow", at, 16384);

    // R1 RTC source and alternate RC code
    cur_req = "R1";
    cfg_src = 2'd2; rc_tick = 1; rtc_tick = 0;
    do_reset();
    run_sched(4500, 0, 0, 0, 0, at, kind);
    chk("R1 RC ignored on RTC code", at, 0);
    rc_tick = 0; rtc_tick = 1;
    do_reset();
    run_sched(5000, 0, 0, 0, 0, at, kind);
    chk("R1 RTC source", at, 4096);
    cfg_src = 2'd3; rc_tick = 1; rtc_tick = 0;
    do_reset();
    run_sched(5000, 0, 0, 0, 0, at, kind);
    chk("R1 code 3 takes RC", at, 4096);
    cfg_src = 2'd0;

    // R5 disabled
    cur_req = "R5";
    cfg_en = 0;
    do_reset();
    run_sched(6000, 100, 1, 200, 4, at, kind);
    chk("R5 no strobe while disabled", at, 0);
    cfg_en = 1;
    run_sched(5000, 0, 0, 0, 0, at, kind);
    chk("R5 count from zero", at, 4096);

    // R2 largest tap
    cur_req = "R2";
    cfg_tap = 2'd3;
    do_reset();
    run_sched(33000, 0, 0, 0, 0, at, kind);
    chk("R2 overflow edge tap3", at, 32768);

    // R12 reset clears flag
    cur_req = "R12";
    rst_n = 0;
    #2;
    chk("R12 to after reset", to_flag_o, 0);
    step();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule